// File: doc/BRIEF.md
# Watchdog Timer with Banded Prescaler Clear

This block is a computer-operating-properly watchdog. Two counters run one after the other on the reference clock: a wide prescaler, then a short watchdog counter that advances each time the prescaler wraps. If software fails to write to the service address before the combined count runs out, the block pulls its active-low reset output low for a fixed number of cycles. It also latches a cause flag, which stays set until power-on reset or an explicit clear.

A service write clears the watchdog counter and the upper band of prescaler bits. The lowest prescaler bits keep running. For this reason each of the two selectable timeouts falls a few cycles short of a power of two. A read of the service address returns a fixed vector byte and leaves the counters alone. A stop indication and the power-up hold both clear the prescaler. A test-mode disable freezes the block.

Top module: `cop_watchdog`

## Requirements
- R1: The prescaler (PRESC_W bits, default 12) advances once per clock. The watchdog counter (WDOG_W bits, default 6) advances once per prescaler wrap. Together they form one combined count.
- R2: With rate select 0, overflow occurs on the clock where the combined PRESC_W+WDOG_W bit count would wrap from all ones. That is 2^18 cycles from a zero count at the defaults.
- R3: With rate select 1, overflow occurs on the clock where the low PRESC_W+SHORT_W bits of the combined count would wrap. That is 2^13 cycles from zero at the defaults.
- R4: A bus write to address SVC_ADDR (default all ones) clears the watchdog counter and prescaler bits above the low KEEP_W bits (default 4). In that same cycle the low KEEP_W bits still advance by one. Writes to any other address have no effect.
- R5: On overflow, rst_n_o goes low on the same clock edge and stays low for exactly PULSE_LEN cycles (default 32). Both counters are held at zero while it is low.
- R6: Overflow sets cop_flag_o on the same edge that rst_n_o falls. The flag stays set until por_i or flag_clr_i. An overflow in the same cycle as flag_clr_i leaves the flag set.
- R7: A bus read of SVC_ADDR makes rd_data_o equal VEC_LO on the next cycle. rd_data_o is zero after any other cycle, and reads do not change the counters.
- R8: stop_i clears the whole prescaler and leaves the watchdog counter unchanged.
- R9: After por_i is released, the prescaler is held at zero for POR_HOLD cycles (default 4096).
- R10: int_rst_i clears both counters and does not cut short a running reset pulse.
- R11: While tst_dis_i is high, the counters do not advance, service writes are ignored and no overflow occurs.
- R12: A service write in the cycle that would overflow wins: no pulse starts and the flag is unchanged.
- R13: During por_i, rst_n_o is 1, cop_flag_o is 0 and rd_data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| int_rst_i | input | 1 | Internal reset, clears both counters |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_rd_i | input | 1 | Bus read strobe |
| bus_addr_i | input | ADDR_W | Bus address |
| stop_i | input | 1 | Stop-instruction indication, clears the prescaler |
| rate_sel_i | input | 1 | 0 selects the long timeout, 1 the short one |
| tst_dis_i | input | 1 | Test-mode disable, freezes the watchdog |
| flag_clr_i | input | 1 | Clears the watchdog-cause flag |
| rst_n_o | output | 1 | Active-low reset drive |
| rd_data_o | output | 8 | Read data for the service address |
| cop_flag_o | output | 1 | Watchdog-cause status flag |

## Verification
A wrong count in either counter shows up at the ports only as a reset pulse that arrives early or late. That can be hundreds of cycles after the fault, so the bench runs a cycle-by-cycle model of the combined count and compares rst_n_o, cop_flag_o and rd_data_o on every clock. A wrong mid-band clear or a lost low-bit advance moves the overflow edge by a few cycles. The bench catches this by servicing at exactly the cycle before overflow, and by timing the gaps from power-up and from an internal reset to the falling edge. A pulse length error shows within PULSE_LEN cycles of the fall.

// File: rtl/cop_pkg.sv
package cop_pkg;
  // Control bundle steering the prescaler each cycle.
  typedef struct packed {
    logic clr_all;  // clear every prescaler stage
    logic clr_mid;  // clear the band above the kept low bits
    logic run;      // advance when nothing clears
  } presc_ctl_t;
endpackage

// File: rtl/cop_prescaler.sv
module cop_prescaler
  import cop_pkg::*;
#(
  parameter int PRESC_W  = 12,
  parameter int KEEP_W   = 4,
  parameter int POR_HOLD = 4096
) (
  input  logic               clk_i,
  input  logic               por_i,
  input  presc_ctl_t         ctl_i,
  output logic [PRESC_W-1:0] presc_o,
  output logic               tick_o
);
  localparam int HOLD_W = $clog2(POR_HOLD + 1);

  logic [HOLD_W-1:0]  hold_cnt;
  logic               hold_act;
  logic               clear;
  logic [PRESC_W-1:0] mid_val;

  assign hold_act = (hold_cnt != HOLD_W'(POR_HOLD));
  assign clear    = ctl_i.clr_all | hold_act;

  always_ff @(posedge clk_i) begin
    if (por_i)         hold_cnt <= '0;
    else if (hold_act) hold_cnt <= hold_cnt + HOLD_W'(1);
  end

  generate
    if (KEEP_W > 0) begin : g_keep
      logic [KEEP_W-1:0] low_inc;
      assign low_inc = presc_o[KEEP_W-1:0] + KEEP_W'(1);
      assign mid_val = {{(PRESC_W-KEEP_W){1'b0}}, low_inc};
    end else begin : g_nokeep
      assign mid_val = '0;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (por_i || clear)     presc_o <= '0;
    else if (ctl_i.clr_mid) presc_o <= mid_val;
    else if (ctl_i.run)     presc_o <= presc_o + PRESC_W'(1);
  end

  assign tick_o = ctl_i.run & ~clear & ~ctl_i.clr_mid & (&presc_o);
endmodule

// File: rtl/cop_counter.sv
module cop_counter #(
  parameter int WDOG_W  = 6,
  parameter int SHORT_W = 1
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic              rate_sel_i,
  output logic [WDOG_W-1:0] cnt_o,
  output logic              ovf_o
);
  logic full;

  assign full  = rate_sel_i ? (&cnt_o[SHORT_W-1:0]) : (&cnt_o);
  assign ovf_o = tick_i & full & ~clr_i;

  always_ff @(posedge clk_i) begin
    if (por_i || clr_i || ovf_o) cnt_o <= '0;
    else if (tick_i)             cnt_o <= cnt_o + WDOG_W'(1);
  end
endmodule

// File: rtl/cop_pulse.sv
module cop_pulse #(
  parameter int PULSE_LEN = 32
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic fire_i,
  output logic active_o,
  output logic rst_n_o
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    if (fire_i)        cnt_nxt = CNT_W'(PULSE_LEN);
    else if (cnt != 0) cnt_nxt = cnt - CNT_W'(1);
    else               cnt_nxt = '0;
  end

  always_ff @(posedge clk_i) begin
    if (por_i) begin
      cnt     <= '0;
      rst_n_o <= 1'b1;
    end else begin
      cnt     <= cnt_nxt;
      rst_n_o <= (cnt_nxt == '0);
    end
  end

  assign active_o = (cnt != '0);

  AST_NO_REFIRE: assert property (@(posedge clk_i) disable iff (por_i)
    active_o |-> !fire_i); // R5
  AST_FALL_FROM_FIRE: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(rst_n_o) |-> $past(fire_i)); // R5
endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog
  import cop_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR = '1,
  parameter logic [7:0]      VEC_LO    = 8'h80,
  parameter int              PRESC_W   = 12,
  parameter int              KEEP_W    = 4,
  parameter int              WDOG_W    = 6,
  parameter int              SHORT_W   = 1,
  parameter int              PULSE_LEN = 32,
  parameter int              POR_HOLD  = 4096
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              int_rst_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              stop_i,
  input  logic              rate_sel_i,
  input  logic              tst_dis_i,
  input  logic              flag_clr_i,
  output logic              rst_n_o,
  output logic [7:0]        rd_data_o,
  output logic              cop_flag_o
);
  logic               svc_hit;
  logic               svc;
  logic               pulse_act;
  logic               tick;
  logic               ovf;
  logic [PRESC_W-1:0] presc;
  logic [WDOG_W-1:0]  wcnt;
  presc_ctl_t         ctl;

  assign svc_hit     = (bus_addr_i == SVC_ADDR);
  assign svc         = bus_wr_i & svc_hit & ~tst_dis_i;
  assign ctl.clr_all = int_rst_i | pulse_act | stop_i;
  assign ctl.clr_mid = svc;
  assign ctl.run     = ~tst_dis_i;

  cop_prescaler #(
    .PRESC_W (PRESC_W),
    .KEEP_W  (KEEP_W),
    .POR_HOLD(POR_HOLD)
  ) u_presc (
    .clk_i  (clk_i),
    .por_i  (por_i),
    .ctl_i  (ctl),
    .presc_o(presc),
    .tick_o (tick)
  );

  cop_counter #(
    .WDOG_W (WDOG_W),
    .SHORT_W(SHORT_W)
  ) u_cnt (
    .clk_i     (clk_i),
    .por_i     (por_i),
    .clr_i     (int_rst_i | pulse_act | svc),
    .tick_i    (tick),
    .rate_sel_i(rate_sel_i),
    .cnt_o     (wcnt),
    .ovf_o     (ovf)
  );

  cop_pulse #(
    .PULSE_LEN(PULSE_LEN)
  ) u_pulse (
    .clk_i   (clk_i),
    .por_i   (por_i),
    .fire_i  (ovf),
    .active_o(pulse_act),
    .rst_n_o (rst_n_o)
  );

  always_ff @(posedge clk_i) begin
    if (por_i)           cop_flag_o <= 1'b0;
    else if (ovf)        cop_flag_o <= 1'b1;
    else if (flag_clr_i) cop_flag_o <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (por_i) rd_data_o <= '0;
    else       rd_data_o <= (bus_rd_i && svc_hit) ? VEC_LO : 8'h00;
  end

  AST_FLAG_WITH_PULSE: assert property (@(posedge clk_i) disable iff (por_i)
    $rose(cop_flag_o) |-> $fell(rst_n_o)); // R6
  AST_RD_VECTOR: assert property (@(posedge clk_i) disable iff (por_i)
    (bus_rd_i && svc_hit) |=> (rd_data_o == VEC_LO)); // R7
  AST_TST_QUIET: assert property (@(posedge clk_i) disable iff (por_i)
    tst_dis_i |-> !ovf); // R11
  AST_SVC_WINS: assert property (@(posedge clk_i) disable iff (por_i)
    svc |-> !ovf); // R12
  AST_INT_CLEARS: assert property (@(posedge clk_i) disable iff (por_i)
    int_rst_i |=> (presc == '0 && wcnt == '0)); // R10
endmodule

// File: tb/cop_watchdog_test.sv
module cop_watchdog_test;
  localparam int CLK_PERIOD = 10;
  localparam int PW   = 6;
  localparam int KW   = 2;
  localparam int WW   = 3;
  localparam int SW   = 1;
  localparam int LEN  = 8;
  localparam int HOLD = 20;
  localparam logic [15:0] SVC = 16'hFFFF;
  localparam logic [7:0]  VEC = 8'h5C;
  localparam int PM   = (1 << PW) - 1;
  localparam int LM   = (1 << KW) - 1;
  localparam int FULL = 1 << (PW + WW);
  localparam int SHRT = 1 << (PW + SW);

  logic clk = 0;
  logic por = 1, int_rst = 0, bus_wr = 0, bus_rd = 0, stop = 0, rate = 0, tst = 0, fclr = 0;
  logic [15:0] addr = 0;
  logic rst_n, flag;
  logic [7:0] rd_data;

  int checks = 0, fails = 0;
  string cur_req = "R13";
  bit done = 0;

  // reference model state
  int m_total = 0, m_hcnt = 0, m_pcnt = 0, m_lim = 0;
  bit m_hold, m_ovf, m_svc;
  bit e_rst_n = 1, e_flag = 0;
  logic [7:0] e_rd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cop_watchdog #(
    .ADDR_W(16), .SVC_ADDR(SVC), .VEC_LO(VEC), .PRESC_W(PW), .KEEP_W(KW),
    .WDOG_W(WW), .SHORT_W(SW), .PULSE_LEN(LEN), .POR_HOLD(HOLD)
  ) uut (
    .clk_i(clk), .por_i(por), .int_rst_i(int_rst), .bus_wr_i(bus_wr),
    .bus_rd_i(bus_rd), .bus_addr_i(addr), .stop_i(stop), .rate_sel_i(rate),
    .tst_dis_i(tst), .flag_clr_i(fclr), .rst_n_o(rst_n), .rd_data_o(rd_data),
    .cop_flag_o(flag)
  );

  always @(posedge clk) begin
    if (por) begin
      m_total = 0; m_hcnt = 0; m_pcnt = 0; e_rst_n = 1; e_flag = 0; e_rd = 0;
    end else begin
      m_hold = (m_hcnt != HOLD);
      m_ovf  = 0;
      m_svc  = bus_wr && (addr == SVC) && !tst;
      if (m_hold) m_hcnt = m_hcnt + 1;
      if (int_rst || m_pcnt > 0) m_total = 0;
      else if (stop || m_hold) begin
        m_total = m_total & ~PM;
        if (m_svc) m_total = 0;
      end else if (m_svc) m_total = (m_total + 1) & LM;
      else if (!tst) begin
        m_lim = rate ? SHRT : FULL;
        if (((m_total + 1) % m_lim) == 0) begin m_ovf = 1; m_total = 0; end
        else m_total = (m_total + 1) % FULL;
      end
      if (m_ovf) m_pcnt = LEN;
      else if (m_pcnt > 0) m_pcnt = m_pcnt - 1;
      e_rst_n = (m_pcnt == 0);
      if (m_ovf) e_flag = 1;
      else if (fclr) e_flag = 0;
      e_rd = (bus_rd && addr == SVC) ? VEC : 8'h00;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk({cur_req, " rst_n"}, int'(rst_n), int'(e_rst_n));
    chk({cur_req, " flag"},  int'(flag),  int'(e_flag));
    chk({cur_req, " rdata"}, int'(rd_data), int'(e_rd));
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic svc_write(logic [15:0] a);
    bus_wr = 1; addr = a; @(negedge clk); bus_wr = 0; addr = 0;
  endtask

  task automatic wait_total(int v);
    int guard = 0;
    while (m_total != v && guard < 5000) begin @(negedge clk); guard++; end
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int n;
    cyc(3);
    cur_req = "R13";
    chk("R13 reset rst_n", int'(rst_n), 1);
    chk("R13 reset flag", int'(flag), 0);
    por = 0;

    // R9 hold then R2 long timeout, R1 counting
    cur_req = "R2";
    n = 0;
    while (rst_n && n < 2000) begin @(negedge clk); n++; end
    chk("R2 R9 cycles to fall", n, HOLD + FULL);
    cur_req = "R5";
    n = 0;
    while (!rst_n && n < 100) begin @(negedge clk); n++; end
    chk("R5 pulse length", n, LEN);
    cur_req = "R6";
    chk("R6 flag set", int'(flag), 1);
    cyc(5);
    chk("R6 flag sticky", int'(flag), 1);
    fclr = 1; cyc(1); fclr = 0; cyc(1);
    chk("R6 flag cleared", int'(flag), 0);

    // R3 short timeout, R10 internal reset restart
    cur_req = "R3";
    rate = 1;
    int_rst = 1; cyc(1); int_rst = 0;
    n = 0;
    while (rst_n && n < 2000) begin @(negedge clk); n++; end
    chk("R3 R10 cycles to fall", n, SHRT);
    int_rst = 1; cyc(2); int_rst = 0;
    chk("R10 pulse not cut", int'(rst_n), 0);
    cyc(LEN + 2);
    fclr = 1; cyc(1); fclr = 0;

    // R4 servicing plus R7 reads
    cur_req = "R4";
    for (int i = 0; i < 6; i++) begin
      cyc(70 + 7 * i);
      svc_write(SVC);
      bus_rd = 1; addr = (i % 2) ? SVC : 16'h1234; cyc(1); bus_rd = 0; addr = 0;
      if (i == 2) svc_write(16'hFFFE);
    end
    chk("R4 no reset when serviced", int'(flag), 0);
    cur_req = "R7";
    bus_rd = 1; addr = SVC; cyc(1); bus_rd = 0; addr = 0;
    chk("R7 vector byte", int'(rd_data), int'(VEC));
    cyc(1);
    chk("R7 zero after", int'(rd_data), 0);

    // R8 stop clears prescaler only
    cur_req = "R8";
    for (int i = 0; i < 5; i++) begin cyc(50); stop = 1; cyc(1); stop = 0; end
    cyc(200);
    chk("R8 overflow after stops", int'(flag), 1);
    fclr = 1; cyc(1); fclr = 0; cyc(LEN);

    // R11 test disable
    cur_req = "R11";
    tst = 1;
    cyc(300); svc_write(SVC); cyc(300);
    chk("R11 no reset", int'(rst_n), 1);
    chk("R11 no flag", int'(flag), 0);
    tst = 0;

    // R12 service on the overflow cycle, short and long rate
    cur_req = "R12";
    int_rst = 1; cyc(1); int_rst = 0;
    wait_total(SHRT - 1);
    svc_write(SVC);
    cyc(3);
    chk("R12 short rst_n", int'(rst_n), 1);
    chk("R12 short flag", int'(flag), 0);
    rate = 0;
    wait_total(FULL - 1);
    svc_write(SVC);
    cyc(3);
    chk("R12 long rst_n", int'(rst_n), 1);
    chk("R12 long flag", int'(flag), 0);

    // R13 power-on reset mid run
    rate = 1;
    cyc(2 * SHRT);
    cur_req = "R13";
    por = 1; cyc(2);
    chk("R13 por flag", int'(flag), 0);
    chk("R13 por rst_n", int'(rst_n), 1);
    por = 0; cyc(HOLD + 10);
    finish_run();
  end
endmodule